// File: doc/BRIEF.md
# Oversampling Asynchronous Character Receiver

This block pulls characters off an asynchronous serial input. It runs on a system clock and uses a single-cycle enable pulse that arrives at sixteen times the bit rate. A falling edge on the idle-high line starts a frame. The first data bit is sampled 24 ticks after that edge, which is the middle of the bit cell. Each later bit is sampled 16 ticks after the one before it. Word length and parity come from two-bit and one-bit control fields that are shared with the companion transmitter. The receiver latches these fields when a frame starts.

A finished character is offered on a valid/ready output. `rx_valid` rises when a byte lands in the holding register. It stays high until a cycle in which `rx_valid` and `rx_ready` are both high, and that cycle consumes the byte. The serial line cannot be stalled, so back-pressure takes the form of overrun. If a character finishes while the previous one is still unconsumed, the new character is dropped, the old byte is kept and an overrun flag is raised. When a new character finishes in the same cycle as a handshake, the new byte is loaded.

The receiver also keeps sticky error flags for overrun, parity, framing and break, reported in one status byte. A pulse on `stat_rd` clears those flags, which models a read of the status register.

Top module: `uart_rx_oversample`

## Requirements
- R1: While idle, a frame starts only on a baud tick at which the synchronised line is 0 and the line was 1 at the previous baud tick.
- R2: The first data bit is sampled on the 24th baud tick after the start tick. Each following bit is sampled 16 ticks after the previous sample.
- R3: The width code `wlen_sel` selects 5, 6, 7 or 8 data bits for codes 00, 01, 10 and 11. Bits are received least significant first, and `rx_data` bits above the word length read 0.
- R4: With `par_en`=1 a parity bit follows the data. For `par_even`=1 it makes the count of ones even, and for `par_even`=0 it makes the count odd. A mismatch sets status bit 2.
- R5: Status bit 0 equals `rx_valid`. It is set when a character is loaded and cleared by a cycle in which `rx_valid` and `rx_ready` are both high.
- R6: A stop bit sampled as 0 sets status bit 3.
- R7: If a character completes while `rx_valid` is 1 and `rx_ready` is 0, status bit 1 is set and `rx_data` keeps the older byte.
- R8: A frame whose data, parity and stop samples are all 0 sets status bit 4, also sets bit 3, and loads the byte 0.
- R9: A pulse on `stat_rd` clears status bits 1 to 4 and leaves bit 0 unchanged. Bits 5 to 7 always read 0.
- R10: After a frame that ends with a low line, no new frame starts until the line has returned high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| wlen_sel | input | 2 | Data width code: 00=5, 01=6, 10=7, 11=8 bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stat_rd | input | 1 | Status read strobe; clears error flags |
| rx_ready | input | 1 | Consumer accepts the held byte |
| rx_valid | output | 1 | Holding register contains an unconsumed byte |
| rx_data | output | 8 | Received byte, zero-extended |
| line_status | output | 8 | {3'b0, break, framing, parity, overrun, valid} |

## Verification
The assertions assume that `baud_tick` is a pulse lasting one clock. They also assume that the line-format fields change only while no frame is in progress. The bench generates the tick from a fixed divider and changes the format fields only between frames, after the line has been idle for a full bit cell. The serial stimulus is driven on the same tick grid with bit cells of exactly 16 ticks. This keeps every sample point well inside its cell, even with the synchroniser delay.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  // Number of data bits selected by the two-bit width code
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return {2'b00, code} + 4'd5;
  endfunction

endpackage

// File: rtl/uart_rx_line_sync.sv
module uart_rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_frame_sampler.sv
module uart_rx_frame_sampler
  import uart_rx_pkg::*;
#(
  parameter int OS         = 16,
  parameter int FIRST_WAIT = 24,
  parameter int DATA_MAX   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                line,
  input  logic [1:0]          wlen_sel,
  input  logic                par_en,
  input  logic                par_even,
  output logic                done,
  output logic [DATA_MAX-1:0] frm_data,
  output logic                frm_perr,
  output logic                frm_ferr,
  output logic                frm_brk
);

  localparam int CNT_W  = $clog2(FIRST_WAIT);
  localparam int IDX_W  = $clog2(DATA_MAX + 3);
  localparam int CHK_W  = $clog2(FIRST_WAIT + OS * (DATA_MAX + 2) + 1);
  localparam int DSEL_W = $clog2(DATA_MAX);

  rx_state_e          st;
  logic               prev_line;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic [3:0]         nd_q;
  logic               pe_q, ev_q;
  logic [DATA_MAX-1:0] dsh;
  logic               pbit;
  logic               any_one;
  logic [IDX_W-1:0]   last_idx;
  logic               start_now, sample_now;

  assign last_idx   = IDX_W'(nd_q) + IDX_W'(pe_q);
  assign start_now  = tick && (st == RX_IDLE) && prev_line && !line;
  assign sample_now = tick && (st == RX_BUSY) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      prev_line <= 1'b1;
      cnt       <= '0;
      idx       <= '0;
      nd_q      <= 4'd8;
      pe_q      <= 1'b0;
      ev_q      <= 1'b0;
      dsh       <= '0;
      pbit      <= 1'b0;
      any_one   <= 1'b0;
    end else if (tick) begin
      case (st)
        RX_IDLE: begin
          prev_line <= line;
          if (start_now) begin
            st      <= RX_BUSY;
            cnt     <= CNT_W'(FIRST_WAIT - 1);
            idx     <= '0;
            dsh     <= '0;
            any_one <= 1'b0;
            nd_q    <= data_bits(wlen_sel);
            pe_q    <= par_en;
            ev_q    <= par_even;
          end
        end
        RX_BUSY: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cnt     <= CNT_W'(OS - 1);
            any_one <= any_one | line;
            idx     <= idx + 1'b1;
            if (idx < IDX_W'(nd_q))
              dsh[idx[DSEL_W-1:0]] <= line;
            else if (pe_q && (idx == IDX_W'(nd_q)))
              pbit <= line;
            if (idx == last_idx) begin
              st        <= RX_IDLE;
              prev_line <= line;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // Frame result, one-cycle pulse after the stop sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      frm_data <= '0;
      frm_perr <= 1'b0;
      frm_ferr <= 1'b0;
      frm_brk  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sample_now && (idx == last_idx)) begin
        done     <= 1'b1;
        frm_data <= dsh;
        frm_ferr <= !line;
        frm_brk  <= !(any_one | line);
        frm_perr <= pe_q && (pbit != ((^dsh) ^ !ev_q));
      end
    end
  end

  // Independent tick counter for checking sample placement
  logic [CHK_W-1:0] chk_t;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 chk_t <= '0;
    else if (start_now)         chk_t <= '0;
    else if (tick && st == RX_BUSY) chk_t <= chk_t + 1'b1;
  end

  AST_SAMPLE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> (int'(chk_t) == FIRST_WAIT - 1 + OS * int'(idx))); // R2

  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st == RX_IDLE && !prev_line) |=> (st == RX_IDLE)); // R10

endmodule

// File: rtl/uart_rx_line_status.sv
module uart_rx_line_status #(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic [DATA_MAX-1:0] frm_data,
  input  logic                frm_perr,
  input  logic                frm_ferr,
  input  logic                frm_brk,
  input  logic                rx_ready,
  input  logic                stat_rd,
  output logic                rx_valid,
  output logic [DATA_MAX-1:0] rx_data,
  output logic [7:0]          line_status
);

  logic ovr_q, pe_q, fe_q, bi_q;
  logic load, drop, take;

  assign take = rx_valid && rx_ready;
  assign load = done && (!rx_valid || rx_ready);
  assign drop = done && rx_valid && !rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (load) begin
        rx_valid <= 1'b1;
        rx_data  <= frm_data;
      end else if (take) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // Sticky error flags: a new set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      ovr_q <= (ovr_q && !stat_rd) || drop;
      pe_q  <= (pe_q  && !stat_rd) || (load && frm_perr);
      fe_q  <= (fe_q  && !stat_rd) || (load && frm_ferr);
      bi_q  <= (bi_q  && !stat_rd) || (load && frm_brk);
    end
  end

  assign line_status = {3'b000, bi_q, fe_q, pe_q, ovr_q, rx_valid};

  AST_DONE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_valid); // R5

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !done) |=> !rx_valid); // R5

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (line_status[1] && $stable(rx_data))); // R7

  AST_BREAK_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && frm_brk) |=> (line_status[4] && line_status[3] && rx_data == '0)); // R8

endmodule

// File: rtl/uart_rx_oversample.sv
module uart_rx_oversample #(
  parameter int OS          = 16,
  parameter int FIRST_WAIT  = 24,
  parameter int DATA_MAX    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic [1:0] wlen_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       stat_rd,
  input  logic       rx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic [7:0] line_status
);

  logic                line_s;
  logic                done;
  logic [DATA_MAX-1:0] frm_data;
  logic                frm_perr, frm_ferr, frm_brk;
  logic [DATA_MAX-1:0] data_w;

  uart_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  uart_rx_frame_sampler #(
    .OS(OS), .FIRST_WAIT(FIRST_WAIT), .DATA_MAX(DATA_MAX)
  ) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .line    (line_s),
    .wlen_sel(wlen_sel),
    .par_en  (par_en),
    .par_even(par_even),
    .done    (done),
    .frm_data(frm_data),
    .frm_perr(frm_perr),
    .frm_ferr(frm_ferr),
    .frm_brk (frm_brk)
  );

  uart_rx_line_status #(.DATA_MAX(DATA_MAX)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .frm_data   (frm_data),
    .frm_perr   (frm_perr),
    .frm_ferr   (frm_ferr),
    .frm_brk    (frm_brk),
    .rx_ready   (rx_ready),
    .stat_rd    (stat_rd),
    .rx_valid   (rx_valid),
    .rx_data    (data_w),
    .line_status(line_status)
  );

  assign rx_data = 8'(data_w);

  AST_STATUS_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[7:5] == 3'b000); // R9

  AST_VALID_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    line_status[0] == rx_valid); // R5

endmodule

// File: tb/uart_rx_oversample_tb.sv
module uart_rx_oversample_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] wlen_sel = 2'b11;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       stat_rd = 1'b0;
  logic       rx_ready = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic [7:0] line_status;

  int checks = 0;
  int errors = 0;
  int tcnt = 0;

  uart_rx_oversample u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .wlen_sel(wlen_sel), .par_en(par_en), .par_even(par_even),
    .stat_rd(stat_rd), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .line_status(line_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      tcnt++;
      baud_tick = (tcnt % TICK_DIV) == 0;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!baud_tick);
    end
    @(negedge clk);
  endtask

  task automatic send_bit(input logic v);
    rxd = v;
    wait_ticks(16);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nd, input logic pe,
                            input logic ev, input logic flip, input logic stopv);
    logic par;
    par = (^(d & 8'((1 << nd) - 1))) ^ !ev ^ flip;
    send_bit(1'b0);
    for (int i = 0; i < nd; i++) send_bit(d[i]);
    if (pe) send_bit(par);
    send_bit(stopv);
    rxd = 1'b1;
    wait_ticks(16);
  endtask

  task automatic do_take();
    rx_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic do_stat();
    stat_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R5 reset status", line_status, 8'h00);
    chk("R3 reset data", rx_data, 8'h00);
    rst_n = 1'b1;
    wait_ticks(40);
    chk("R1 idle line gives no frame", {7'b0, rx_valid}, 8'h00);

    // Sweep: every width, every parity mode, sixteen patterns each
    for (int wl = 0; wl < 4; wl++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int i = 0; i < 16; i++) begin
          int nd;
          logic [7:0] mask, d;
          nd   = wl + 5;
          mask = 8'((1 << nd) - 1);
          d    = (i == 15) ? mask : (8'(i * 73 + 11) & mask);
          wlen_sel = 2'(wl);
          par_en   = (pm != 0);
          par_even = (pm == 1);
          // R2 mid-bit sampling across all patterns
          send_frame(8'(i * 73 + 11) | ((i == 15) ? 8'hFF : 8'h00), nd, par_en, par_even, 1'b0, 1'b1);
          chk("R3 R2 data width and order", rx_data, d);
          chk("R4 R5 clean status", line_status, 8'h01);
          do_take();
          chk("R5 handshake clears valid", line_status, 8'h00);
        end
      end
    end

    // Parity errors in both senses
    wlen_sel = 2'b11; par_en = 1'b1; par_even = 1'b1;
    send_frame(8'h5A, 8, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R4 even parity error", line_status, 8'h05);
    chk("R4 data with parity error", rx_data, 8'h5A);
    do_stat(); do_take();
    par_even = 1'b0;
    send_frame(8'h07, 8, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 odd parity error", line_status, 8'h05);
    do_stat(); do_take();

    // Framing error and clear-on-status-read
    par_en = 1'b0;
    send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 framing flag", line_status, 8'h09);
    chk("R6 data kept", rx_data, 8'hC3);
    do_stat();
    chk("R9 status read clears errors only", line_status, 8'h01);
    do_take();
    chk("R9 R5 all clear", line_status, 8'h00);

    // Overrun
    send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7 overrun flag", line_status, 8'h03);
    chk("R7 older byte kept", rx_data, 8'hA5);
    do_stat();
    chk("R9 overrun cleared", line_status, 8'h01);
    do_take();

    // Break with line held low past the frame
    rxd = 1'b0;
    wait_ticks(16 * 10 + 48);
    chk("R8 break status", line_status, 8'h19);
    chk("R8 break byte", rx_data, 8'h00);
    do_stat(); do_take();
    wait_ticks(64);
    chk("R10 low line after break starts nothing", line_status, 8'h00);
    rxd = 1'b1;
    wait_ticks(48);
    chk("R10 release gives no frame", line_status, 8'h00);
    send_frame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 reception resumes", rx_data, 8'h81);
    chk("R10 clean status", line_status, 8'h01);

    summary();
    $finish;
  end

endmodule